// File: doc/BRIEF.md
# Ingress Frame Priority Classifier

This block watches the opening bytes of each frame as it comes in from a receive MAC and marks the frame as high or low priority. Bytes arrive one per accepted cycle. `valid_i` qualifies each byte, `sof_i` flags the first byte and `eof_i` flags the last byte. Bytes are counted from the first byte of the destination address.

Three tests are combined with a logical OR, and each test can be switched on or off on its own:

- **Port test:** the ingress port number falls inside a low range of ports.
- **VLAN test:** a VLAN tag is present and carries a high user priority.
- **DiffServ test:** an IPv4 or IPv6 header carries one of a fixed set of codepoints.

The switches come from strap pins, which are captured once after reset. The result appears as a one-cycle strobe with a priority bit. The strobe follows the byte that settles the outcome. If the frame ends before that byte, the strobe follows the last byte instead. A downstream queue selector consumes the strobe.

Top module: `qos_classifier`

## Requirements
- R1: The straps are captured on the first rising clock edge after `rst_ni` goes high. Any later change on a strap pin has no effect until the next reset.
- R2: Port strap `strap_port_pri_i` gives a port range. 00 means no port is high. 01 means ports 0–1 are high, 10 means ports 0–3 are high, and 11 means ports 0–7 are high. The port number is taken from `port_id_i` with the `sof_i` byte.
- R3: A frame is tagged when bytes 12–13 are 0x81,0x00. Its user priority is bits 7:5 of byte 14. Values 4–7 count as high when `strap_vlan_pri_i` was set.
- R4: The EtherType sits at bytes 12–13 of an untagged frame and at bytes 16–17 of a tagged frame. Only 0x0800 leads to IP parsing. The first IP byte is byte 14 (untagged) or byte 18 (tagged). Its upper nibble must be 4 or 6; any other version yields no codepoint.
- R5: For version 4 the codepoint is bits 7:2 of the second IP byte. For version 6 it is {first IP byte[3:0], second IP byte[7:6]}.
- R6: The high codepoints are 46, 10, 18, 26, 34, 48 and 56. All other codepoints are low. The DiffServ test counts only when `strap_ds_pri_i` was set.
- R7: The frame is high when any enabled test matches. A disabled test never raises the result.
- R8: `prio_valid_o` pulses for one cycle, exactly once per frame. It pulses the cycle after the deciding byte:
  - the second IP byte, for an IP frame;
  - the EtherType low byte, for a non-IP frame;
  - the `eof_i` byte, if that comes earlier.
- R9: A frame that ends before its header is complete is low unless the port test, or an already received high user priority, applies.
- R10: `prio_high_o` is 0 whenever `prio_valid_o` is 0. Both outputs are 0 during reset.
- R11: Cycles with `valid_i` low neither advance the byte count nor produce a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_port_pri_i | input | 2 | Port-range strap |
| strap_vlan_pri_i | input | 1 | VLAN user priority test enable strap |
| strap_ds_pri_i | input | 1 | DiffServ test enable strap |
| valid_i | input | 1 | Byte qualifier |
| sof_i | input | 1 | First byte of frame |
| eof_i | input | 1 | Last byte of frame |
| data_i | input | 8 | Frame byte |
| port_id_i | input | 4 | Ingress port, sampled with `sof_i` |
| prio_valid_o | output | 1 | Decision strobe |
| prio_high_o | output | 1 | Decision: 1 = high priority |

## Verification
The hardest cases are frames that end right at a header boundary. Examples are a tagged frame whose last byte is the user priority byte, or a tagged IP frame that stops on its first IP byte. In both, the decision must use partly parsed state and still fire exactly once.

The stimulus replays a fixed set of frames for every one of the sixteen strap combinations. The set includes truncated frames cut at bytes 10, 14 and 18, and other frames have idle gaps between bytes. A scoreboard compares both the priority bit and the byte position at which the strobe appears.

// File: rtl/qos_cls_pkg.sv
package qos_cls_pkg;

  typedef struct packed {
    logic [1:0] port_mode;
    logic       vlan_en;
    logic       ds_en;
  } qos_cfg_t;

  // EF, AF11/21/31/41, class selectors 6 and 7
  function automatic logic dscp_is_high(input logic [5:0] d);
    logic hit;
    unique case (d)
      6'd46, 6'd10, 6'd18, 6'd26, 6'd34: hit = 1'b1;
      default:                           hit = (d[5:4] == 2'b11) && (d[2:0] == 3'b000);
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/qos_strap_latch.sv
module qos_strap_latch
  import qos_cls_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] port_pri_i,
  input  logic       vlan_en_i,
  input  logic       ds_en_i,
  output qos_cfg_t   cfg_o
);

  logic     lock_q;
  qos_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      cfg_q  <= '0;
    end else if (!lock_q) begin
      lock_q <= 1'b1;
      cfg_q  <= '{port_mode: port_pri_i, vlan_en: vlan_en_i, ds_en: ds_en_i};
    end
  end

  assign cfg_o = cfg_q;

  assert_cfg_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(cfg_q));

endmodule

// File: rtl/qos_hdr_parser.sv
module qos_hdr_parser #(
  parameter int          CNT_W   = 5,
  parameter logic [15:0] TPID    = 16'h8100,
  parameter logic [15:0] IP_TYPE = 16'h0800,
  parameter int          PCP_MIN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic [7:0] data_i,
  output logic       fire_o,
  output logic       frame_done_o,
  output logic       vlan_hi_o,
  output logic       ds_valid_o,
  output logic [5:0] dscp_o
);

  localparam logic [CNT_W-1:0] IDX_TYPE_HI_U = CNT_W'(12);
  localparam logic [CNT_W-1:0] IDX_TYPE_LO_U = CNT_W'(13);
  localparam logic [CNT_W-1:0] IDX_PCP       = CNT_W'(14);
  localparam logic [CNT_W-1:0] IDX_TYPE_HI_T = CNT_W'(16);
  localparam logic [CNT_W-1:0] IDX_TYPE_LO_T = CNT_W'(17);
  localparam logic [CNT_W-1:0] IDX_IP0_U     = CNT_W'(14);
  localparam logic [CNT_W-1:0] IDX_IP0_T     = CNT_W'(18);
  localparam logic [CNT_W-1:0] IDX_IP1_U     = CNT_W'(15);
  localparam logic [CNT_W-1:0] IDX_IP1_T     = CNT_W'(19);
  localparam logic [CNT_W-1:0] IDX_MAX       = '1;
  localparam logic [2:0]       PCP_THR       = 3'(PCP_MIN);

  logic [CNT_W-1:0] cnt_q, idx, ip0, ip1;
  logic             tagged_q, ip_q, done_q, pcp_ok_q;
  logic [7:0]       hi_q, ver_q;
  logic [2:0]       pcp_q;

  logic        tag_now, ip_now, done_now, pcp_ok_now;
  logic [15:0] etype;
  logic        at_tpid, at_inner, tag_set, type_seen, ip_set;
  logic        at_ip0, at_ip1, at_pcp, final_byte, fire;
  logic [3:0]  ver_nib;

  always_comb begin
    idx        = sof_i ? '0 : cnt_q;
    tag_now    = !sof_i && tagged_q;
    ip_now     = !sof_i && ip_q;
    done_now   = !sof_i && done_q;
    pcp_ok_now = !sof_i && pcp_ok_q;
    ip0        = tag_now ? IDX_IP0_T : IDX_IP0_U;
    ip1        = tag_now ? IDX_IP1_T : IDX_IP1_U;
    etype      = {hi_q, data_i};
    at_tpid    = !tag_now && (idx == IDX_TYPE_LO_U);
    at_inner   = tag_now && (idx == IDX_TYPE_LO_T);
    tag_set    = at_tpid && (etype == TPID);
    type_seen  = (at_tpid && !tag_set) || at_inner;
    ip_set     = type_seen && (etype == IP_TYPE);
    at_ip0     = ip_now && (idx == ip0);
    at_ip1     = ip_now && (idx == ip1);
    at_pcp     = tag_now && (idx == IDX_PCP);
    final_byte = (type_seen && !ip_set) || at_ip1;
    fire       = valid_i && !done_now && (final_byte || eof_i);
    ver_nib    = ver_q[7:4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      tagged_q <= 1'b0;
      ip_q     <= 1'b0;
      done_q   <= 1'b0;
      pcp_ok_q <= 1'b0;
      hi_q     <= '0;
      ver_q    <= '0;
      pcp_q    <= '0;
    end else if (valid_i) begin
      cnt_q    <= (idx == IDX_MAX) ? idx : idx + CNT_W'(1);
      tagged_q <= tag_now || tag_set;
      ip_q     <= ip_now || ip_set;
      done_q   <= done_now || fire;
      pcp_ok_q <= pcp_ok_now || at_pcp;
      if (idx == IDX_TYPE_HI_U || (tag_now && idx == IDX_TYPE_HI_T)) hi_q <= data_i;
      if (at_ip0) ver_q <= data_i;
      if (at_pcp) pcp_q <= data_i[7:5];
    end
  end

  assign fire_o       = fire;
  assign frame_done_o = done_now;
  assign vlan_hi_o    = tag_now && (at_pcp ? (data_i[7:5] >= PCP_THR)
                                           : (pcp_ok_now && pcp_q >= PCP_THR));
  assign ds_valid_o   = at_ip1 && (ver_nib == 4'd4 || ver_nib == 4'd6);
  assign dscp_o       = (ver_nib == 4'd6) ? {ver_q[3:0], data_i[7:6]} : data_i[7:2];

  // R11: a byte slot with valid low must not disturb the frame position
  assert_gap_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q) && $stable(done_q));

endmodule

// File: rtl/qos_prio_merge.sv
module qos_prio_merge
  import qos_cls_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  qos_cfg_t          cfg_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [PORT_W-1:0] port_id_i,
  input  logic              fire_i,
  input  logic              vlan_hi_i,
  input  logic              ds_valid_i,
  input  logic [5:0]        dscp_i,
  output logic              prio_valid_o,
  output logic              prio_high_o
);

  logic [PORT_W-1:0] port_q, port_now;
  logic [PORT_W:0]   port_lim;
  logic              port_hit, high;
  logic              valid_q, high_q;

  always_comb begin
    port_now = sof_i ? port_id_i : port_q;
    unique case (cfg_i.port_mode)
      2'b01:   port_lim = (PORT_W+1)'(2);
      2'b10:   port_lim = (PORT_W+1)'(4);
      2'b11:   port_lim = (PORT_W+1)'(8);
      default: port_lim = '0;
    endcase
    port_hit = {1'b0, port_now} < port_lim;
    high     = port_hit
             || (cfg_i.vlan_en && vlan_hi_i)
             || (cfg_i.ds_en && ds_valid_i && dscp_is_high(dscp_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q  <= '0;
      valid_q <= 1'b0;
      high_q  <= 1'b0;
    end else begin
      if (valid_i && sof_i) port_q <= port_id_i;
      valid_q <= fire_i;
      high_q  <= fire_i && high;
    end
  end

  assign prio_valid_o = valid_q;
  assign prio_high_o  = high_q;

endmodule

// File: rtl/qos_classifier.sv
module qos_classifier
  import qos_cls_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_port_pri_i,
  input  logic              strap_vlan_pri_i,
  input  logic              strap_ds_pri_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic [7:0]        data_i,
  input  logic [PORT_W-1:0] port_id_i,
  output logic              prio_valid_o,
  output logic              prio_high_o
);

  qos_cfg_t   cfg;
  logic       fire, frame_done, vlan_hi, ds_valid;
  logic [5:0] dscp;

  qos_strap_latch i_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_pri_i (strap_port_pri_i),
    .vlan_en_i  (strap_vlan_pri_i),
    .ds_en_i    (strap_ds_pri_i),
    .cfg_o      (cfg)
  );

  qos_hdr_parser #(.CNT_W(CNT_W)) i_parser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .sof_i        (sof_i),
    .eof_i        (eof_i),
    .data_i       (data_i),
    .fire_o       (fire),
    .frame_done_o (frame_done),
    .vlan_hi_o    (vlan_hi),
    .ds_valid_o   (ds_valid),
    .dscp_o       (dscp)
  );

  qos_prio_merge #(.PORT_W(PORT_W)) i_merge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .valid_i      (valid_i),
    .sof_i        (sof_i),
    .port_id_i    (port_id_i),
    .fire_i       (fire),
    .vlan_hi_i    (vlan_hi),
    .ds_valid_i   (ds_valid),
    .dscp_i       (dscp),
    .prio_valid_o (prio_valid_o),
    .prio_high_o  (prio_high_o)
  );

  assert_eof_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && eof_i && !frame_done |=> prio_valid_o);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !prio_valid_o);

  assert_high_qualified_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prio_valid_o |-> !prio_high_o);

  assert_port_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sof_i && eof_i && cfg.port_mode == 2'b11 && port_id_i < PORT_W'(8)
    |=> prio_high_o);

  assert_short_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sof_i && eof_i && cfg.port_mode == 2'b00 |=> !prio_high_o);

endmodule

// File: tb/test_qos_classifier.sv
module test_qos_classifier;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_pm = 2'b00;
  logic       strap_v = 1'b0, strap_d = 1'b0;
  logic       valid = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0] data = '0;
  logic [3:0] port = '0;
  logic       prio_valid, prio_high;

  always #2 clk = ~clk;

  qos_classifier i_qos_classifier (
    .clk_i(clk), .rst_ni(rst_n),
    .strap_port_pri_i(strap_pm), .strap_vlan_pri_i(strap_v), .strap_ds_pri_i(strap_d),
    .valid_i(valid), .sof_i(sof), .eof_i(eof), .data_i(data), .port_id_i(port),
    .prio_valid_o(prio_valid), .prio_high_o(prio_high)
  );

  typedef struct { bit hi; int idx; string tag; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0, bytes_sent = 0;
  logic [7:0] fr [0:63];
  int cfg_pm; bit cfg_v, cfg_d;

  // R2 R3 R4 R5 R6 R7 R9: expected priority and deciding byte from the requirements
  task automatic ref_model(input int p, input int len, output bit hi, output int idx);
    bit tag = 0, ip = 0, vlan, ds = 0, ph;
    int fin = len - 1, ip0, lim;
    logic [5:0] dscp;
    logic [3:0] ver;
    if (len >= 14) begin
      if (fr[12] == 8'h81 && fr[13] == 8'h00) tag = 1;
      if (!tag) begin
        if (fr[12] == 8'h08 && fr[13] == 8'h00) ip = 1; else fin = 13;
      end else if (len >= 18) begin
        if (fr[16] == 8'h08 && fr[17] == 8'h00) ip = 1; else fin = 17;
      end
    end
    ip0 = tag ? 18 : 14;
    if (ip) fin = ip0 + 1;
    idx = (fin < len - 1) ? fin : len - 1;
    vlan = tag && idx >= 14 && fr[14][7:5] >= 3'd4;
    if (ip && idx == ip0 + 1) begin
      ver = fr[ip0][7:4];
      dscp = (ver == 4'd6) ? {fr[ip0][3:0], fr[ip0+1][7:6]} : fr[ip0+1][7:2];
      ds = (ver == 4'd4 || ver == 4'd6) && (dscp inside {6'd46, 6'd10, 6'd18, 6'd26, 6'd34, 6'd48, 6'd56});
    end
    lim = (cfg_pm == 0) ? 0 : (1 << cfg_pm);
    ph = p < lim;
    hi = ph || (cfg_v && vlan) || (cfg_d && ds);
  endtask

  task automatic build(input bit tag, input logic [2:0] pcp, input logic [15:0] et,
                       input logic [3:0] ver, input logic [5:0] dscp);
    int ip0;
    for (int i = 0; i < 64; i++) fr[i] = 8'(i + 8'h20);
    if (tag) begin
      fr[12] = 8'h81; fr[13] = 8'h00; fr[14] = {pcp, 5'h0}; fr[15] = 8'h05;
      fr[16] = et[15:8]; fr[17] = et[7:0]; ip0 = 18;
    end else begin
      fr[12] = et[15:8]; fr[13] = et[7:0]; ip0 = 14;
    end
    fr[ip0]   = (ver == 4'd6) ? {4'h6, dscp[5:2]} : {ver, 4'h5};
    fr[ip0+1] = (ver == 4'd6) ? {dscp[1:0], 6'h0} : {dscp, 2'b00};
  endtask

  task automatic send(input int p, input int len, input bit gap, input string tag);
    exp_t e;
    ref_model(p, len, e.hi, e.idx);
    e.tag = tag;
    exp_q.push_back(e);
    bytes_sent = 0;
    for (int i = 0; i < len; i++) begin
      valid = 1'b1; sof = (i == 0); eof = (i == len - 1); data = fr[i]; port = 4'(p);
      @(posedge clk); #1;
      bytes_sent = i + 1;
      if (gap && (i % 3 == 1)) begin
        valid = 1'b0; sof = 1'b0; eof = 1'b0; data = 8'hxx;
        @(posedge clk); #1;
      end
    end
    valid = 1'b0; sof = 1'b0; eof = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input int pm, input bit v, input bit d);
    rst_n = 1'b0; strap_pm = 2'(pm); strap_v = v; strap_d = d;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;  // R10 reset state
    if (prio_valid !== 1'b0 || prio_high !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset outputs valid=%b high=%b expected 0 0", prio_valid, prio_high);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    cfg_pm = pm; cfg_v = v; cfg_d = d;
    repeat (2) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: R7 R8 priority and strobe position
  always @(negedge clk) begin
    if (rst_n && prio_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 extra strobe high=%b expected no strobe", prio_high);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (prio_high !== e.hi || bytes_sent - 1 != e.idx) begin
          n_fail++;
          $display("FAIL R7/R8 %s: high=%b at byte %0d expected high=%b at byte %0d",
                   e.tag, prio_high, bytes_sent - 1, e.hi, e.idx);
        end
      end
    end else if (rst_n && prio_high !== 1'b0) begin
      n_chk++; n_fail++;
      $display("FAIL R10 prio_high=%b without strobe expected 0", prio_high);
    end
  end

  task automatic frame_set;
    build(0, 0, 16'h0800, 4, 6'd46); send(0, 40, 0, "R5 v4 EF");
    build(1, 5, 16'h0806, 4, 6'd0);  send(9, 30, 1, "R3 tag pcp5 non-IP");
    build(1, 3, 16'h0800, 6, 6'd34); send(3, 48, 0, "R5 tag v6 AF41");
    build(0, 0, 16'h0800, 4, 6'd0);  send(7, 20, 1, "R6 v4 best effort");
    build(0, 0, 16'h0800, 6, 6'd56); send(15, 60, 0, "R6 v6 cs7");
    build(0, 0, 16'h0806, 4, 6'd46); send(1, 14, 0, "R4 non-IP len14");
    build(0, 0, 16'h0800, 5, 6'd46); send(12, 30, 0, "R4 bad version");
    build(0, 0, 16'h0800, 4, 6'd46); send(0, 10, 0, "R9 runt");
    build(1, 7, 16'h0800, 4, 6'd46); send(12, 15, 0, "R9 ends on pcp byte");
    build(0, 0, 16'h0800, 4, 6'd52); send(5, 25, 0, "R6 dscp 52");
    build(0, 0, 16'h0800, 4, 6'd47); send(2, 25, 1, "R6 dscp 47");
    build(1, 4, 16'h0800, 4, 6'd10); send(6, 19, 0, "R9 ends on first IP byte");
    build(0, 0, 16'h0800, 4, 6'd48); send(11, 64, 0, "R6 cs6");
    build(1, 0, 16'h0800, 6, 6'd18); send(14, 40, 1, "R5 tag v6 AF21 gaps R11");
  endtask

  initial begin
    for (int pm = 0; pm < 4; pm++)
      for (int v = 0; v < 2; v++)
        for (int d = 0; d < 2; d++) begin
          do_reset(pm, v[0], d[0]);
          frame_set();
        end
    // R1: pins move after capture, the latched settings stay in force
    do_reset(3, 1, 1);
    strap_pm = 2'b00; strap_v = 1'b0; strap_d = 1'b0;
    build(0, 0, 16'h0806, 4, 6'd0);  send(2, 20, 0, "R1 port strap kept");
    build(1, 6, 16'h0806, 4, 6'd0);  send(13, 20, 0, "R1 vlan strap kept");
    build(0, 0, 16'h0800, 4, 6'd26); send(13, 20, 0, "R1 ds strap kept");
    repeat (5) @(posedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R8 %0d strobes missing expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired expected run to complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule